// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces memory addresses for post-modify indirect accesses. It keeps a small set of pointer registers. Each pointer has its own index, base and length register. An access names one pointer, an update mode and a modify value. The modify value may come from any general register, so it arrives as a plain input. In the cycle after the access, the block presents the pointer's current index as the address. At the same clock edge it replaces the index with the updated value.

Three update modes are available. The linear mode adds the modify value. The circular mode adds it and folds the result back into the window that starts at base and spans length words. The bit-reverse mode adds with the carry running from the most significant bit toward the least significant bit, which steps through FFT-style reordered sequences. A write to an index takes effect on the next cycle. A write to a base or length register only reaches the address arithmetic after a fixed configuration latency. Memory and instruction decode sit outside this block.

Top module: `ptr_agen`

## Requirements
- R1: After synchronous reset, every index, base and length register reads as zero and `addr_valid` is low.
- R2: A write with `wr_sel` = 0 loads the index of pointer `wr_ptr` for the next cycle. When an access to the same pointer happens in the same cycle, the access emits the old index and the written value replaces the update. A write with `wr_sel` = 3 changes nothing.
- R3: An access emits the pointer's current index on `addr_out` with `addr_valid` high one cycle later (post-modify). `addr_valid` is low in the cycle after a cycle with no access.
- R4: Mode 0 (and mode 3, treated the same way) sets the index to index + modify, modulo 2^32.
- R5: Mode 1 with a nonzero length computes s = index + modify. If s >= base + length, the new index is s - length. If s < base, the new index is s + length. Otherwise the new index is s. The magnitude of modify must not exceed length.
- R6: In mode 1, with length 4 and modify 1, four accesses from base bring the index back to base.
- R7: In mode 1, a length of zero turns the update into the plain add of R4.
- R8: Mode 2 updates the index by reverse-carry addition: each bit position's carry goes to the next lower bit, and the carry out of bit 0 is dropped.
- R9: A base write (`wr_sel` = 1) or length write (`wr_sel` = 2) made in cycle c is seen by accesses issued in cycle c+4 or later. Accesses issued in cycles c through c+3 use the previous value.
- R10: An access changes only the index of the pointer it names. The other indices keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 index, 1 base, 2 length, 3 none |
| wr_ptr | input | PW (2) | Pointer number for the write |
| wr_data | input | AW (32) | Write value |
| acc_en | input | 1 | Access request |
| acc_ptr | input | PW (2) | Pointer used by the access |
| acc_mode | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 linear |
| acc_mod | input | AW (32) | Modify value (two's complement) |
| addr_valid | output | 1 | Address on `addr_out` is from an access one cycle earlier |
| addr_out | output | AW (32) | Generated address (index before update) |

## Verification
The hardest case to reach is the configuration window: an access that lands exactly on the cycle a delayed length write becomes visible. The bench writes a new length and then issues circular accesses on every following cycle, starting one cycle after the write. The index is placed so that the address stream differs depending on whether the wrap begins one cycle early, on time, or one cycle late. A second hard case is a simultaneous index write and access to the same pointer. The bench drives both in one cycle and then reads the index back with a zero modify.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_CIRC   = 2'd1,
    AM_BREV   = 2'd2,
    AM_ALT    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    RS_INDEX  = 2'd0,
    RS_BASE   = 2'd1,
    RS_LENGTH = 2'd2,
    RS_NONE   = 2'd3
  } rsel_e;
endpackage

// File: rtl/agen_rc_add.sv
module agen_rc_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W-1:0] a_rev, b_rev, s_rev;

  // mirror operands, add normally, mirror back: carries run toward bit 0
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign a_rev[i] = a[W-1-i];
    assign b_rev[i] = b[W-1-i];
    assign sum[i]   = s_rev[W-1-i];
  end

  assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/agen_next.sv
module agen_next
  import ptr_agen_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] modv,
  input  logic [W-1:0] base,
  input  logic [W-1:0] len,
  input  logic [1:0]   mode,
  output logic [W-1:0] nxt
);
  logic [W-1:0] lin_sum, win_end, circ_val, brev_val;
  amode_e       md;

  assign md      = amode_e'(mode);
  assign lin_sum = idx + modv;
  assign win_end = base + len;

  always_comb begin
    if (len == '0)                circ_val = lin_sum;
    else if (lin_sum >= win_end)  circ_val = lin_sum - len;
    else if (lin_sum < base)      circ_val = lin_sum + len;
    else                          circ_val = lin_sum;
  end

  agen_rc_add #(.W(W)) u_rc (
    .a   (idx),
    .b   (modv),
    .sum (brev_val)
  );

  always_comb begin
    case (md)
      AM_CIRC: nxt = circ_val;
      AM_BREV: nxt = brev_val;
      default: nxt = lin_sum;
    endcase
  end
endmodule

// File: rtl/agen_cfg_delay.sv
module agen_cfg_delay #(
  parameter int W     = 32,
  parameter int PW    = 2,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic          in_is_len,
  input  logic [PW-1:0] in_ptr,
  input  logic [W-1:0]  in_data,
  output logic          out_vld,
  output logic          out_is_len,
  output logic [PW-1:0] out_ptr,
  output logic [W-1:0]  out_data
);
  typedef struct packed {
    logic          vld;
    logic          is_len;
    logic [PW-1:0] ptr;
    logic [W-1:0]  data;
  } stage_t;

  stage_t stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= '{vld: in_vld, is_len: in_is_len, ptr: in_ptr, data: in_data};
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign out_vld    = stg[DEPTH-1].vld;
  assign out_is_len = stg[DEPTH-1].is_len;
  assign out_ptr    = stg[DEPTH-1].ptr;
  assign out_data   = stg[DEPTH-1].data;
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NPTR    = 4,
  parameter int CFG_LAT = 4,
  localparam int PW     = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int DEPTH  = CFG_LAT - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [PW-1:0] wr_ptr,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_en,
  input  logic [PW-1:0] acc_ptr,
  input  logic [1:0]    acc_mode,
  input  logic [AW-1:0] acc_mod,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);
  logic [NPTR-1:0][AW-1:0] idx_q, base_q, len_q;
  logic [AW-1:0]           cur_idx, cur_base, cur_len, nxt_idx;
  rsel_e                   wsel;
  logic                    cfg_vld;
  logic                    cm_vld, cm_is_len;
  logic [PW-1:0]           cm_ptr;
  logic [AW-1:0]           cm_data;

  assign wsel    = rsel_e'(wr_sel);
  assign cfg_vld = wr_en && (wsel == RS_BASE || wsel == RS_LENGTH);

  agen_cfg_delay #(.W(AW), .PW(PW), .DEPTH(DEPTH)) u_dly (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (cfg_vld),
    .in_is_len  (wsel == RS_LENGTH),
    .in_ptr     (wr_ptr),
    .in_data    (wr_data),
    .out_vld    (cm_vld),
    .out_is_len (cm_is_len),
    .out_ptr    (cm_ptr),
    .out_data   (cm_data)
  );

  assign cur_idx  = idx_q[acc_ptr];
  assign cur_base = base_q[acc_ptr];
  assign cur_len  = len_q[acc_ptr];

  agen_next #(.W(AW)) u_next (
    .idx  (cur_idx),
    .modv (acc_mod),
    .base (cur_base),
    .len  (cur_len),
    .mode (acc_mode),
    .nxt  (nxt_idx)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    localparam logic [PW-1:0] PID = PW'(p);

    always_ff @(posedge clk) begin
      if (rst)
        idx_q[p] <= '0;
      else if (wr_en && wsel == RS_INDEX && wr_ptr == PID)
        idx_q[p] <= wr_data;
      else if (acc_en && acc_ptr == PID)
        idx_q[p] <= nxt_idx;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[p] <= '0;
        len_q[p]  <= '0;
      end else if (cm_vld && cm_ptr == PID) begin
        if (cm_is_len) len_q[p]  <= cm_data;
        else           base_q[p] <= cm_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= acc_en;
      if (acc_en) addr_out <= cur_idx;
    end
  end
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int AW   = 32,
  parameter int NPTR = 4,
  parameter int PW   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic [PW-1:0]           wr_ptr,
  input logic                    acc_en,
  input logic [PW-1:0]           acc_ptr,
  input logic [1:0]              acc_mode,
  input logic [AW-1:0]           acc_mod,
  input logic                    addr_valid,
  input logic [AW-1:0]           addr_out,
  input logic [NPTR-1:0][AW-1:0] idx_q,
  input logic [NPTR-1:0][AW-1:0] base_q,
  input logic [NPTR-1:0][AW-1:0] len_q,
  input logic                    cm_vld,
  input logic                    cm_is_len
);
  // R1: reset leaves no address pending and indices cleared
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!addr_valid && idx_q == '0));

  // R3: valid strobe follows the access request by one cycle
  p_valid_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_valid);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !addr_valid);

  // R3: emitted address is the index as it stood before the update
  p_addr_is_old_idx_r3: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> addr_out == $past(idx_q[acc_ptr]));

  // R5: an in-window circular step with a small positive modify stays in the window
  p_circ_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_mode == 2'd1 && len_q[acc_ptr] != '0 &&
     acc_mod < len_q[acc_ptr] &&
     idx_q[acc_ptr] >= base_q[acc_ptr] &&
     (idx_q[acc_ptr] - base_q[acc_ptr]) < len_q[acc_ptr] &&
     !(wr_en && wr_sel == 2'd0 && wr_ptr == acc_ptr))
    |=> (idx_q[$past(acc_ptr)] >= $past(base_q[acc_ptr]) &&
         (idx_q[$past(acc_ptr)] - $past(base_q[acc_ptr])) < $past(len_q[acc_ptr])));

  // R9: base and length only move when the delay line delivers a commit
  p_base_only_on_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !(cm_vld && !cm_is_len) |=> $stable(base_q));

  p_len_only_on_commit_r9: assert property (@(posedge clk) disable iff (rst)
    !(cm_vld && cm_is_len) |=> $stable(len_q));

  // R10: an index untouched by access and write holds its value
  for (genvar p = 0; p < NPTR; p++) begin : g_hold
    localparam logic [PW-1:0] PID = PW'(p);
    p_idx_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!(acc_en && acc_ptr == PID) && !(wr_en && wr_sel == 2'd0 && wr_ptr == PID))
      |=> $stable(idx_q[p]));
  end
endmodule

bind ptr_agen ptr_agen_chk #(.AW(AW), .NPTR(NPTR), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_ptr     (wr_ptr),
  .acc_en     (acc_en),
  .acc_ptr    (acc_ptr),
  .acc_mode   (acc_mode),
  .acc_mod    (acc_mod),
  .addr_valid (addr_valid),
  .addr_out   (addr_out),
  .idx_q      (idx_q),
  .base_q     (base_q),
  .len_q      (len_q),
  .cm_vld     (cm_vld),
  .cm_is_len  (cm_is_len)
);

// File: tb/tb_ptr_agen.sv
`timescale 1ns/1ps
module tb_ptr_agen;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [1:0]  wr_ptr;
  logic [31:0] wr_data;
  logic        acc_en;
  logic [1:0]  acc_ptr;
  logic [1:0]  acc_mode;
  logic [31:0] acc_mod;
  logic        addr_valid;
  logic [31:0] addr_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] keep3;

  always #2 clk = ~clk;

  ptr_agen dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .acc_en(acc_en), .acc_ptr(acc_ptr), .acc_mode(acc_mode), .acc_mod(acc_mod),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reverse-carry add, bit by bit from the top down
  function automatic logic [31:0] rc_ref(input logic [31:0] a, input logic [31:0] b);
    logic c = 1'b0;
    logic [31:0] s;
    for (int i = 31; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  // circular step expressed as an offset modulo the length
  function automatic logic [31:0] circ_ref(input logic [31:0] idx, input int m,
                                           input logic [31:0] base, input int len);
    int off;
    if (len == 0) return idx + 32'(m);
    off = int'(idx - base);
    off = ((off + m) % len + len) % len;
    return base + 32'(off);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [1:0] p, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_ptr = p; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic acc(input string tag, input logic [1:0] p, input logic [1:0] md,
                     input logic [31:0] m, input logic [31:0] exp);
    acc_en = 1'b1; acc_ptr = p; acc_mode = md; acc_mod = m;
    @(posedge clk); @(negedge clk);
    acc_en = 1'b0;
    chk({tag, " valid"}, {31'd0, addr_valid}, 32'd1);
    chk(tag, addr_out, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid low after reset", {31'd0, addr_valid}, 32'd0);
    for (int p = 0; p < 4; p++) acc("R1 index zero", 2'(p), 2'd0, 32'd0, 32'd0);
    // base/length zero: circular acts as plain add from zero
    acc("R1 length zero circ", 2'd1, 2'd1, 32'd7, 32'd0);
    acc("R1 length zero circ next", 2'd1, 2'd0, 32'd0, 32'd7);
  endtask

  task automatic t_index_write();
    wr(2'd0, 2'd0, 32'h40);
    acc("R2 index loaded", 2'd0, 2'd0, 32'd1, 32'h40);
    // same-cycle write and access on pointer 0
    wr_en = 1'b1; wr_sel = 2'd0; wr_ptr = 2'd0; wr_data = 32'h500;
    acc_en = 1'b1; acc_ptr = 2'd0; acc_mode = 2'd0; acc_mod = 32'd1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
    chk("R2 collide emits old index", addr_out, 32'h41);
    acc("R2 write wins over update", 2'd0, 2'd0, 32'd0, 32'h500);
    wr(2'd3, 2'd0, 32'hDEAD);
    idle(4);
    acc("R2 select 3 ignored", 2'd0, 2'd0, 32'd0, 32'h500);
  endtask

  task automatic t_linear();
    wr(2'd0, 2'd1, 32'hFFFF_FFFE);
    acc("R4 linear first", 2'd1, 2'd0, 32'd3, 32'hFFFF_FFFE);
    acc("R4 linear wraps 2^32", 2'd1, 2'd3, 32'h10, 32'h1);
    acc("R4 mode 3 adds", 2'd1, 2'd0, 32'd0, 32'h11);
    idle(1);
    chk("R3 valid low when idle", {31'd0, addr_valid}, 32'd0);
  endtask

  task automatic t_circ_wrap();
    logic [31:0] e;
    wr(2'd1, 2'd2, 32'h1000);
    wr(2'd2, 2'd2, 32'd4);
    wr(2'd0, 2'd2, 32'h1000);
    idle(4);
    for (int k = 0; k < 4; k++) acc("R6 step", 2'd2, 2'd1, 32'd1, 32'h1000 + 32'(k));
    acc("R6 back at base", 2'd2, 2'd1, 32'd3, 32'h1000);
    e = 32'h1003;
    for (int k = 0; k < 6; k++) begin
      acc("R5 modify 3", 2'd2, 2'd1, 32'd3, e);
      e = circ_ref(e, 3, 32'h1000, 4);
    end
  endtask

  task automatic t_circ_neg();
    logic [31:0] e;
    wr(2'd1, 2'd3, 32'h200);
    wr(2'd2, 2'd3, 32'd5);
    wr(2'd0, 2'd3, 32'h202);
    idle(4);
    e = 32'h202;
    for (int k = 0; k < 6; k++) begin
      acc("R5 negative modify", 2'd3, 2'd1, 32'hFFFF_FFFE, e);
      e = circ_ref(e, -2, 32'h200, 5);
    end
    keep3 = e;
  endtask

  task automatic t_len_zero();
    wr(2'd1, 2'd0, 32'h300);
    wr(2'd0, 2'd0, 32'h3FE);
    idle(4);
    acc("R7 len0 first", 2'd0, 2'd1, 32'd4, 32'h3FE);
    acc("R7 len0 no wrap", 2'd0, 2'd1, 32'd4, 32'h402);
  endtask

  task automatic t_cfg_latency();
    wr(2'd0, 2'd1, 32'h100);
    wr(2'd1, 2'd1, 32'h100);
    wr(2'd2, 2'd1, 32'd0);
    idle(4);
    wr(2'd2, 2'd1, 32'd2);   // write in cycle c, accesses from c+1
    acc("R9 c+1 old length", 2'd1, 2'd1, 32'd1, 32'h100);
    acc("R9 c+2 old length", 2'd1, 2'd1, 32'd1, 32'h101);
    acc("R9 c+3 old length", 2'd1, 2'd1, 32'd1, 32'h102);
    acc("R9 c+4 new length", 2'd1, 2'd1, 32'd1, 32'h103);
    acc("R9 wrapped by new length", 2'd1, 2'd0, 32'd0, 32'h102);
  endtask

  task automatic t_brev();
    logic [31:0] e;
    wr(2'd0, 2'd2, 32'h0200_A5A5);
    acc("R8 emits index", 2'd2, 2'd2, 32'h2121, 32'h0200_A5A5);
    acc("R8 reverse-carry", 2'd2, 2'd0, 32'd0, rc_ref(32'h0200_A5A5, 32'h2121));
    wr(2'd0, 2'd2, 32'd0);
    e = 32'd0;
    for (int k = 0; k < 9; k++) begin
      acc("R8 reversed sequence", 2'd2, 2'd2, 32'h1000_0000, e);
      e = rc_ref(e, 32'h1000_0000);
    end
    acc("R10 other pointer kept", 2'd3, 2'd0, 32'd0, keep3);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_ptr = 2'd0; wr_data = '0;
    acc_en = 1'b0; acc_ptr = 2'd0; acc_mode = 2'd0; acc_mod = '0; keep3 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_index_write();
    t_linear();
    t_circ_wrap();
    t_circ_neg();
    t_len_zero();
    t_cfg_latency();
    t_brev();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule